// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch

A square crosspoint switch that connects each of its outputs to any one of its inputs, or to nothing. The routing map sits in two copies. A shadow copy takes new programming from a clocked write port: each write names an output and the input it should follow. A live copy drives the data-path multiplexers, so the map actually in use changes only when a copy is made.

An active-low update strobe, synchronized into the configuration clock, copies the whole shadow map into the live map on one edge. All outputs therefore switch over at the same moment. While the strobe is held low the live map tracks the shadow map on every edge, and each write takes effect at once. The data path from inputs to outputs is purely combinational. A global output enable forces every output to 0. Reset clears both maps.

Top module: `xbar_dbuf`

## Requirements
- R1: While rst_ni is low and after it rises, both maps are empty. Every output drives 0 for any data_i, including after an update copy that follows reset.
- R2: A write with update_ni high changes only the shadow map, and data_o keeps following the previous live map.
- R3: A copy moves every shadow entry into the live map on the same configuration-clock edge, so several outputs reconfigure together.
- R4: With update_ni held low, a write on a rising edge is visible at data_o right after that same edge.
- R5: Each output has at most one driver. A new write to an output replaces its earlier input, and the earlier input no longer reaches that output.
- R6: With oe_i high, a connected output data_o[o] equals data_i[s], where s is the input last written for o and copied. The path is combinational. An unconnected output drives 0.
- R7: With oe_i low, data_o is all zeros whatever the map and the data.
- R8: On an edge where prog_en_i is low, prog_out_i and prog_in_i are ignored and neither map changes.
- R9: update_ni passes through two flops. If it goes low between edges A and B, edges B and C make no copy, and the first copy happens on the edge after C.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| oe_i | input | 1 | Output enable; low forces all outputs to 0 |
| update_ni | input | 1 | Active-low copy strobe from shadow to live map |
| prog_en_i | input | 1 | Write qualifier for the programming port |
| prog_out_i | input | OAW (7) | Output address of a write |
| prog_in_i | input | IAW (7) | Input address that the written output will follow |
| data_i | input | N_IN (128) | Switched data inputs |
| data_o | output | N_OUT (128) | Switched data outputs |

## Verification
The routing is checked under several data_i patterns: all ones, single bits lit at chosen inputs, and pseudo-random words. All ones shows which outputs are connected at all. A single lit bit shows which input an output follows, and this separates a replaced driver from the new one. Random words catch swapped or shifted select indices across the whole map. A full 128-output remap, made while the strobe stays high and then copied, shows that no output moves early and that all of them move on one edge.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;
  function automatic int unsigned addr_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/xbar_upd_sync.sv
`timescale 1ns/1ps
module xbar_upd_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic update_ni,
  output logic copy_o
);
  logic [1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= 2'b11;
    else         s_q <= {s_q[0], update_ni};
  end

  assign copy_o = ~s_q[1];

  p_two_stage_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_q[1] |-> $past(!s_q[0]));
endmodule

// File: rtl/xbar_cfg_store.sv
`timescale 1ns/1ps
module xbar_cfg_store #(
  parameter int unsigned N_IN  = 128,
  parameter int unsigned N_OUT = 128,
  parameter int unsigned IAW   = 7,
  parameter int unsigned OAW   = 7
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      copy_i,
  input  logic                      we_i,
  input  logic [OAW-1:0]            wr_out_i,
  input  logic [IAW-1:0]            wr_in_i,
  output logic [N_OUT-1:0]          act_vld_o,
  output logic [N_OUT-1:0][IAW-1:0] act_sel_o
);
  localparam logic [OAW:0] NOUT_L = N_OUT[OAW:0];
  localparam logic [IAW:0] NIN_L  = N_IN[IAW:0];

  logic [N_OUT-1:0]          sh_vld_q, sh_vld_n;
  logic [N_OUT-1:0][IAW-1:0] sh_sel_q, sh_sel_n;
  logic                      wr_ok;

  assign wr_ok = we_i && ({1'b0, wr_out_i} < NOUT_L) && ({1'b0, wr_in_i} < NIN_L);

  // a write replaces the whole column: one driver per output
  always_comb begin
    sh_vld_n = sh_vld_q;
    sh_sel_n = sh_sel_q;
    if (wr_ok) begin
      sh_vld_n[wr_out_i] = 1'b1;
      sh_sel_n[wr_out_i] = wr_in_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_vld_q  <= '0;
      sh_sel_q  <= '0;
      act_vld_o <= '0;
      act_sel_o <= '0;
    end else begin
      sh_vld_q <= sh_vld_n;
      sh_sel_q <= sh_sel_n;
      if (copy_i) begin
        act_vld_o <= sh_vld_n;  // same-edge write joins the copy
        act_sel_o <= sh_sel_n;
      end
    end
  end

  p_live_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !copy_i |=> ($stable(act_vld_o) && $stable(act_sel_o)));

  p_copy_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_i |=> (act_vld_o == sh_vld_q && act_sel_o == sh_sel_q));

  p_idle_port_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(sh_vld_q) && $stable(sh_sel_q)));

  p_single_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (sh_vld_q[$past(wr_out_i)] && sh_sel_q[$past(wr_out_i)] == $past(wr_in_i)));
endmodule

// File: rtl/xbar_mux.sv
`timescale 1ns/1ps
module xbar_mux #(
  parameter int unsigned N_IN  = 128,
  parameter int unsigned N_OUT = 128,
  parameter int unsigned IAW   = 7
) (
  input  logic [N_IN-1:0]           data_i,
  input  logic                      oe_i,
  input  logic [N_OUT-1:0]          vld_i,
  input  logic [N_OUT-1:0][IAW-1:0] sel_i,
  output logic [N_OUT-1:0]          data_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_col
    assign data_o[o] = oe_i & vld_i[o] & data_i[sel_i[o]];
  end
endmodule

// File: rtl/xbar_dbuf.sv
`timescale 1ns/1ps
module xbar_dbuf #(
  parameter  int unsigned N_IN  = 128,
  parameter  int unsigned N_OUT = 128,
  localparam int unsigned IAW   = xbar_pkg::addr_w(N_IN),
  localparam int unsigned OAW   = xbar_pkg::addr_w(N_OUT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             oe_i,
  input  logic             update_ni,
  input  logic             prog_en_i,
  input  logic [OAW-1:0]   prog_out_i,
  input  logic [IAW-1:0]   prog_in_i,
  input  logic [N_IN-1:0]  data_i,
  output logic [N_OUT-1:0] data_o
);
  logic                      copy;
  logic [N_OUT-1:0]          act_vld;
  logic [N_OUT-1:0][IAW-1:0] act_sel;

  xbar_upd_sync i_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .update_ni (update_ni),
    .copy_o    (copy)
  );

  xbar_cfg_store #(.N_IN(N_IN), .N_OUT(N_OUT), .IAW(IAW), .OAW(OAW)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .copy_i    (copy),
    .we_i      (prog_en_i),
    .wr_out_i  (prog_out_i),
    .wr_in_i   (prog_in_i),
    .act_vld_o (act_vld),
    .act_sel_o (act_sel)
  );

  xbar_mux #(.N_IN(N_IN), .N_OUT(N_OUT), .IAW(IAW)) i_mux (
    .data_i (data_i),
    .oe_i   (oe_i),
    .vld_i  (act_vld),
    .sel_i  (act_sel),
    .data_o (data_o)
  );

  p_oe_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> data_o == '0);
endmodule

// File: tb/test_xbar_dbuf.sv
`timescale 1ns/1ps
module test_xbar_dbuf;
  localparam int N = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         oe = 1'b1;
  logic         upd_n = 1'b1;
  logic         pen = 1'b0;
  logic [6:0]   pout = '0;
  logic [6:0]   pin = '0;
  logic [N-1:0] din = '0;
  logic [N-1:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit sh_vld [N];
  int sh_sel [N];
  bit ac_vld [N];
  int ac_sel [N];
  bit transp = 1'b0;

  always #5 clk = ~clk;

  xbar_dbuf i_xbar_dbuf (
    .clk_i(clk), .rst_ni(rst_n), .oe_i(oe), .update_ni(upd_n),
    .prog_en_i(pen), .prog_out_i(pout), .prog_in_i(pin),
    .data_i(din), .data_o(dout)
  );

  function automatic logic [N-1:0] expected();
    logic [N-1:0] e;
    for (int o = 0; o < N; o++) e[o] = oe && ac_vld[o] && din[ac_sel[o]];
    return e;
  endfunction

  task automatic check(string req, logic [N-1:0] exp_v);
    checks++;
    if (dout !== exp_v) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, dout, exp_v);
    end
  endtask

  task automatic check_model(string req);
    check(req, expected());
  endtask

  task automatic clear_model();
    for (int o = 0; o < N; o++) begin
      sh_vld[o] = 0; sh_sel[o] = 0; ac_vld[o] = 0; ac_sel[o] = 0;
    end
  endtask

  task automatic copy_model();
    for (int o = 0; o < N; o++) begin
      ac_vld[o] = sh_vld[o]; ac_sel[o] = sh_sel[o];
    end
  endtask

  task automatic prog(int o, int i);
    @(negedge clk);
    pen = 1'b1; pout = o[6:0]; pin = i[6:0];
    @(posedge clk);
    sh_vld[o] = 1; sh_sel[o] = i;
    if (transp) begin ac_vld[o] = 1; ac_sel[o] = i; end
    @(negedge clk);
    pen = 1'b0;
  endtask

  // strobe low between edges; copy lands on the third edge after
  task automatic pulse_update(string req);
    @(negedge clk);
    upd_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 check_model("R9 no copy before sync");
    @(posedge clk);
    copy_model();
    #1 check_model(req);
    @(negedge clk);
    upd_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    din = '1;
    #1 check('0, '0);
    checks--; check("R1 in reset", '0);
    @(negedge clk); rst_n = 1'b1;
    clear_model();
    @(negedge clk); check("R1 after reset", '0);
    pulse_update("R1 copy of empty shadow");
    check("R1 empty after copy", '0);
  endtask

  task automatic t_shadow_hold();
    din = '1;
    prog(0, 5); prog(127, 0); prog(64, 127);
    #1 check("R2 live unchanged", '0);
    pulse_update("R3 copy three outputs");
    check("R6 all ones", (N'(1) << 0) | (N'(1) << 127) | (N'(1) << 64));
  endtask

  task automatic t_patterns();
    din = '0; din[5] = 1'b1;
    #1 check_model("R6 input 5 only");
    din = '0; din[127] = 1'b1;
    #1 check_model("R6 input 127 only");
    din = '0; din[0] = 1'b1;
    #1 check_model("R6 input 0 only");
    for (int k = 0; k < 4; k++) begin
      din = {$urandom, $urandom, $urandom, $urandom};
      #1 check_model("R6 random word");
    end
  endtask

  task automatic t_reassign();
    prog(0, 9);
    din = '0; din[9] = 1'b1;
    #1 check("R2 old driver still live", '0);
    pulse_update("R3 reassign copy");
    din = '0; din[5] = 1'b1;
    #1 check("R5 old input gone", '0);
    din = '0; din[9] = 1'b1;
    #1 check("R5 new input drives", N'(1));
  endtask

  task automatic t_en_low();
    @(negedge clk);
    pen = 1'b0; pout = 7'd1; pin = 7'd3;
    repeat (3) @(posedge clk);
    pulse_update("R8 idle port copy");
    din = '1;
    #1 check_model("R8 output 1 stays open");
    checks++;
    if (dout[1] !== 1'b0) begin
      errors++; $display("FAIL R8: out1 got %b expected 0", dout[1]);
    end
  endtask

  task automatic t_oe();
    din = '1;
    oe = 1'b0;
    #1 check("R7 oe low", '0);
    din = {$urandom, $urandom, $urandom, $urandom};
    #1 check("R7 oe low random", '0);
    oe = 1'b1;
    #1 check_model("R7 oe back high");
  endtask

  task automatic t_full_map();
    din = {$urandom, $urandom, $urandom, $urandom};
    for (int o = 0; o < N; o++) prog(o, (o * 37 + 11) % N);
    #1 check_model("R2 full remap held back");
    pulse_update("R3 full remap at once");
    for (int k = 0; k < 3; k++) begin
      din = {$urandom, $urandom, $urandom, $urandom};
      #1 check_model("R6 full map random");
    end
  endtask

  task automatic t_transparent();
    @(negedge clk);
    upd_n = 1'b0;
    repeat (3) @(posedge clk);
    copy_model();
    transp = 1'b1;
    din = '0; din[20] = 1'b1;
    @(negedge clk);
    pen = 1'b1; pout = 7'd10; pin = 7'd20;
    @(posedge clk);
    sh_vld[10] = 1; sh_sel[10] = 20; ac_vld[10] = 1; ac_sel[10] = 20;
    #1 check_model("R4 same edge");
    checks++;
    if (dout[10] !== 1'b1) begin
      errors++; $display("FAIL R4: out10 got %b expected 1", dout[10]);
    end
    @(negedge clk); pen = 1'b0;
    prog(11, 21);
    din[21] = 1'b1;
    #1 check_model("R4 second write");
    @(negedge clk);
    upd_n = 1'b1; transp = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset_mid();
    din = '1;
    @(negedge clk); rst_n = 1'b0;
    #1 check("R1 reset mid run", '0);
    @(negedge clk); rst_n = 1'b1;
    clear_model();
    pulse_update("R1 shadow cleared by reset");
    check("R1 all open", '0);
  endtask

  initial begin
    clear_model();
    repeat (3) @(posedge clk);
    t_reset();
    t_shadow_hold();
    t_patterns();
    t_reassign();
    t_en_low();
    t_oe();
    t_full_map();
    t_transparent();
    t_reset_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule